// File: doc/BRIEF.md
# Windowed Memory Bandwidth Monitor

This block sits next to a memory controller and watches its request/grant stream. During a measurement window it counts the cycles that carry a valid request, the granted transfers in total, and the granted transfers seen by each of four filter channels. Each counted grant stands for one 16-byte transfer. Software turns a count into bytes by multiplying it; the block itself does not do that arithmetic.

Each channel picks the master ports it counts with a 32-bit major mask, indexed by the port ID. Port 23 is a shared device group. A grant from that port also has to hit the channel's 16-bit sub-port mask, indexed by the sub-port ID. A window can be bounded by a one-shot timer. When the timer runs out, counting stops, the counters freeze and a status flag raises a level interrupt. Software reads the counters, writes the control word back to clear the flag, and writes the control word again to open the next window.

Top module: `bw_monitor`

## Requirements
- R1: After reset every register reads 0 and irq_o is low.
- R2: Word addresses: 0x20 control; for channel k the major mask is at 0x21+2k and the sub-port mask at 0x22+2k (the sub mask reads back its low 16 bits); 0x29 request count; 0x2A grant count; 0x2B+k channel k count; 0x2F timer load. Control bits are: 31 enable, 30 interrupt status, 20 timer mode, 3:0 channel enables. Other addresses read 0, and writes to them change nothing.
- R3: A control write with bit 31 set clears all six counters, loads the window timer from 0x2F and starts a window.
- R4: While a window runs, the request counter rises by one in each cycle with req_valid_i high. The grant counter rises in each cycle with both req_valid_i and req_gnt_i high.
- R5: For a grant from a port other than 23, channel k counts it when channel-enable bit k is set and major-mask bit [port] is set.
- R6: For a grant from port 23, channel k also needs sub-mask bit [sub-port] set. With both masks at 0 a channel counts nothing.
- R7: In timer mode the window covers exactly max(load,1) cycles, starting at the cycle after the enabling write. Then the status bit sets, counting stops and the counters hold.
- R8: With timer mode off, counting goes on while enable is set. A control write with bit 31 clear stops the window, and the counters keep their values.
- R9: irq_o equals status AND enable. A control write with bit 30 set clears status. One with bit 30 clear leaves it.
- R10: Counters saturate at 0xFFFFFFFF.
- R11: A write to a counter register loads the written value, 0 clears it, and it wins over an increment in the same cycle.
- R12: A control write wins over a timer expiry in the same cycle. The write then sets enable and window state, and status keeps its prior value unless bit 30 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| req_valid_i | input | 1 | A request is present this cycle |
| req_gnt_i | input | 1 | The request is granted this cycle |
| req_port_i | input | 5 | Master port ID of the request |
| req_sub_i | input | 4 | Sub-port ID, used for port 23 |
| irq_o | output | 1 | Level interrupt: window expired |

## Verification
Assertions check on every cycle that counters move by at most one, that they hold when nothing increments them and stick at all ones, that a port-23 grant never matches without its sub-mask bit, that an enabling write starts a window, that an expiring window stops and raises status, and that status rises only from a running timed window. The exact counts per channel under mixed port and sub-port traffic, the window length and the freezing after expiry, and the same-cycle priority of writes can only be shown by the bench's reference model and its directed scenarios. The bench compares every register read and the interrupt against that model on each clock, through directed and randomised traffic.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int unsigned CTRL_OFS  = 32'h20;
  localparam int unsigned MASK_BASE = 32'h21;
  localparam int unsigned CNT_BASE  = 32'h29;  // request, grant, then channels
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned IRQ_BIT   = 30;
  localparam int unsigned TMODE_BIT = 20;
endpackage

// File: rtl/bwm_sat_counter.sv
module bwm_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (we_i)                  cnt_q <= wdata_i;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !we_i && !clr_i) |=> cnt_q == '1);
  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !we_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bwm_chan_filter.sv
module bwm_chan_filter #(
  parameter int PORT_W   = 5,
  parameter int SUB_W    = 4,
  parameter int DATA_W   = 32,
  parameter int DEV_PORT = 23,
  localparam int MAJ_N   = 1 << PORT_W,
  localparam int SUB_N   = 1 << SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              major_we_i,
  input  logic              sub_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic              match_o,
  output logic [MAJ_N-1:0]  major_o,
  output logic [SUB_N-1:0]  sub_o
);
  logic [MAJ_N-1:0] major_q;
  logic [SUB_N-1:0] sub_q;
  logic             is_dev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      major_q <= '0;
      sub_q   <= '0;
    end else begin
      if (major_we_i) major_q <= wdata_i[MAJ_N-1:0];
      if (sub_we_i)   sub_q   <= wdata_i[SUB_N-1:0];
    end
  end

  assign is_dev  = (port_i == PORT_W'(DEV_PORT));
  assign match_o = major_q[port_i] && (!is_dev || sub_q[sub_i]);
  assign major_o = major_q;
  assign sub_o   = sub_q;

  p_dev_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_dev && !sub_q[sub_i]) |-> !match_o);
  p_plain_port_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_dev && major_q[port_i]) |-> match_o);
endmodule

// File: rtl/bwm_window.sv
module bwm_window
  import bwm_pkg::*;
#(
  parameter int TMR_W  = 32,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              tmr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic              tmode_o,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              status_o,
  output logic              active_o,
  output logic              start_o,
  output logic [TMR_W-1:0]  load_o
);
  logic              en_q, tmode_q, status_q, active_q;
  logic [NUM_CH-1:0] ch_en_q;
  logic [TMR_W-1:0]  load_q, rem_q;
  logic              last_tick;

  assign start_o   = ctrl_we_i && wdata_i[EN_BIT];
  assign last_tick = active_q && tmode_q && (rem_q <= TMR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      tmode_q  <= 1'b0;
      ch_en_q  <= '0;
      status_q <= 1'b0;
      active_q <= 1'b0;
      rem_q    <= '0;
      load_q   <= '0;
    end else begin
      if (tmr_we_i) load_q <= wdata_i[TMR_W-1:0];
      if (ctrl_we_i) begin
        en_q     <= wdata_i[EN_BIT];
        tmode_q  <= wdata_i[TMODE_BIT];
        ch_en_q  <= wdata_i[NUM_CH-1:0];
        active_q <= wdata_i[EN_BIT];
        if (wdata_i[IRQ_BIT]) status_q <= 1'b0;
        if (wdata_i[EN_BIT])  rem_q    <= load_q;
      end else if (last_tick) begin
        active_q <= 1'b0;
        status_q <= 1'b1;
      end else if (active_q && tmode_q) begin
        rem_q <= rem_q - TMR_W'(1);
      end
    end
  end

  assign en_o     = en_q;
  assign tmode_o  = tmode_q;
  assign ch_en_o  = ch_en_q;
  assign status_o = status_q;
  assign active_o = active_q;
  assign load_o   = load_q;

  p_start_runs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[EN_BIT]) |=> active_q);
  p_expiry_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_tick && !ctrl_we_i) |=> (!active_q && status_q));
  p_status_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past(active_q && tmode_q));
  p_ctrl_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[IRQ_BIT]) |=> status_q == $past(status_q));
endmodule

// File: rtl/bw_monitor.sv
module bw_monitor
  import bwm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int TMR_W    = 32,
  parameter int NUM_CH   = 4,
  parameter int PORT_W   = 5,
  parameter int SUB_W    = 4,
  parameter int DEV_PORT = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  input  logic              req_gnt_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [SUB_W-1:0]  req_sub_i,
  output logic              irq_o
);
  localparam int MAJ_N   = 1 << PORT_W;
  localparam int SUB_N   = 1 << SUB_W;
  localparam int NCNT    = NUM_CH + 2;
  localparam int TMR_OFS = CNT_BASE + NCNT;

  logic              en, tmode, status, active, start;
  logic [NUM_CH-1:0] ch_en, match;
  logic [TMR_W-1:0]  load;
  logic              ctrl_we, tmr_we;
  logic [MAJ_N-1:0]  major [NUM_CH];
  logic [SUB_N-1:0]  sub   [NUM_CH];
  logic [CNT_W-1:0]  cnt   [NCNT];
  logic [NCNT-1:0]   cnt_inc;
  logic              grant;

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_OFS));
  assign tmr_we  = reg_we_i && (reg_addr_i == ADDR_W'(TMR_OFS));
  assign grant   = active && req_valid_i && req_gnt_i;

  bwm_window #(.TMR_W(TMR_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_window (
    .clk_i, .rst_ni,
    .ctrl_we_i(ctrl_we), .tmr_we_i(tmr_we), .wdata_i(reg_wdata_i),
    .en_o(en), .tmode_o(tmode), .ch_en_o(ch_en), .status_o(status),
    .active_o(active), .start_o(start), .load_o(load)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    bwm_chan_filter #(.PORT_W(PORT_W), .SUB_W(SUB_W), .DATA_W(DATA_W),
                      .DEV_PORT(DEV_PORT)) u_filter (
      .clk_i, .rst_ni,
      .major_we_i(reg_we_i && reg_addr_i == ADDR_W'(MASK_BASE + 2*k)),
      .sub_we_i  (reg_we_i && reg_addr_i == ADDR_W'(MASK_BASE + 2*k + 1)),
      .wdata_i(reg_wdata_i), .port_i(req_port_i), .sub_i(req_sub_i),
      .match_o(match[k]), .major_o(major[k]), .sub_o(sub[k])
    );
    assign cnt_inc[2+k] = grant && ch_en[k] && match[k];
  end

  assign cnt_inc[0] = active && req_valid_i;
  assign cnt_inc[1] = grant;

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    bwm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i(cnt_inc[j]), .clr_i(start),
      .we_i(reg_we_i && reg_addr_i == ADDR_W'(CNT_BASE + j)),
      .wdata_i(reg_wdata_i[CNT_W-1:0]), .cnt_o(cnt[j])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CTRL_OFS)) begin
      reg_rdata_o[EN_BIT]       = en;
      reg_rdata_o[IRQ_BIT]      = status;
      reg_rdata_o[TMODE_BIT]    = tmode;
      reg_rdata_o[NUM_CH-1:0]   = ch_en;
    end
    for (int k = 0; k < NUM_CH; k++) begin
      if (reg_addr_i == ADDR_W'(MASK_BASE + 2*k))     reg_rdata_o[MAJ_N-1:0] = major[k];
      if (reg_addr_i == ADDR_W'(MASK_BASE + 2*k + 1)) reg_rdata_o[SUB_N-1:0] = sub[k];
    end
    for (int j = 0; j < NCNT; j++)
      if (reg_addr_i == ADDR_W'(CNT_BASE + j)) reg_rdata_o[CNT_W-1:0] = cnt[j];
    if (reg_addr_i == ADDR_W'(TMR_OFS)) reg_rdata_o[TMR_W-1:0] = load;
  end

  assign irq_o = status && en;
endmodule

// File: tb/bw_monitor_tb.sv
module bw_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rv = 1'b0, gnt = 1'b0;
  logic [4:0]  port = '0;
  logic [3:0]  sub = '0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bw_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .req_valid_i(rv), .req_gnt_i(gnt), .req_port_i(port), .req_sub_i(sub),
    .irq_o(irq)
  );

  // reference model state
  bit          m_en, m_tm, m_st, m_act;
  bit [3:0]    m_chen;
  bit [31:0]   m_load, m_rem;
  bit [31:0]   m_major [4];
  bit [15:0]   m_sub [4];
  longint unsigned m_cnt [6];

  function automatic bit [31:0] m_read(bit [7:0] a);
    if (a == 8'h20) return {m_en, m_st, 9'd0, m_tm, 16'd0, m_chen};
    if (a >= 8'h21 && a <= 8'h28) begin
      int k = (a - 8'h21) / 2;
      return ((a - 8'h21) % 2 == 0) ? m_major[k] : {16'd0, m_sub[k]};
    end
    if (a >= 8'h29 && a <= 8'h2E) return m_cnt[a - 8'h29][31:0];
    if (a == 8'h2F) return m_load;
    return 32'd0;
  endfunction

  function automatic string tag_of(bit [7:0] a);
    if (a == 8'h20) return "R9";
    if (a == 8'h29 || a == 8'h2A) return "R4";
    if (a >= 8'h2B && a <= 8'h2E) return "R5";
    return "R2";
  endfunction

  function automatic void sat_inc(int j);
    if (m_cnt[j] < 64'hFFFF_FFFF) m_cnt[j]++;
  endfunction

  function automatic void m_step(bit w, bit [7:0] a, bit [31:0] d,
                                 bit v, bit g, bit [4:0] p, bit [3:0] s);
    bit st0 = m_st;
    bit [31:0] rem0 = m_rem;
    if (m_act) begin
      if (v) sat_inc(0);
      if (v && g) begin
        sat_inc(1);
        for (int k = 0; k < 4; k++)
          if (m_chen[k] && m_major[k][p] && (p != 5'd23 || m_sub[k][s])) sat_inc(2 + k);
      end
      if (m_tm) begin
        if (m_rem <= 1) begin m_act = 0; m_st = 1; end
        else m_rem = m_rem - 1;
      end
    end
    if (w) begin
      if (a == 8'h20) begin
        m_en = d[31]; m_tm = d[20]; m_chen = d[3:0];
        m_st = d[30] ? 1'b0 : st0;
        m_act = d[31];
        m_rem = d[31] ? m_load : rem0;
        if (d[31]) for (int j = 0; j < 6; j++) m_cnt[j] = 0;
      end else if (a == 8'h2F) m_load = d;
      else if (a >= 8'h21 && a <= 8'h28) begin
        int k = (a - 8'h21) / 2;
        if ((a - 8'h21) % 2 == 0) m_major[k] = d; else m_sub[k] = d[15:0];
      end else if (a >= 8'h29 && a <= 8'h2E) m_cnt[a - 8'h29] = d;
    end
  endfunction

  task automatic chk(bit [31:0] got, bit [31:0] exp, string tag, string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // compare against model, then drive the next cycle's inputs
  task automatic cycle(bit w, bit [7:0] a, bit [31:0] d,
                       bit v, bit g, bit [4:0] p, bit [3:0] s);
    @(negedge clk);
    chk(rdata, m_read(addr), tag_of(addr), $sformatf("model read @%h", addr));
    chk({31'd0, irq}, {31'd0, m_st & m_en}, "R9", "irq vs model");
    we = w; addr = a; wdata = d; rv = v; gnt = g; port = p; sub = s;
    m_step(w, a, d, v, g, p, s);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    cycle(1, a, d, 0, 0, 0, 0);
  endtask

  task automatic expect_reg(bit [7:0] a, bit [31:0] exp, string tag);
    cycle(0, a, 0, 0, 0, 0, 0);
    #1 chk(rdata, exp, tag, $sformatf("read @%h", a));
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog got=timeout exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 8'h20; a <= 8'h2F; a++) expect_reg(8'(a), 0, "R1");
    #1 chk({31'd0, irq}, 0, "R1", "irq after reset");

    // R5 R6 R7: timed window with mixed ports
    wr(8'h21, 32'h0000_0008);
    wr(8'h23, 32'h0080_0000);
    wr(8'h24, 32'h0000_0020);
    wr(8'h25, 32'h0080_0008);
    wr(8'h2F, 32'd10);
    wr(8'h20, 32'h8010_000F);
    for (int i = 0; i < 13; i++)
      cycle(0, 8'h29, 0, 1, 1, (i % 2) ? 5'd23 : 5'd3, (i < 4) ? 4'd5 : 4'd6);
    #1 chk({31'd0, irq}, 1, "R9", "irq after expiry");
    expect_reg(8'h29, 10, "R7");
    expect_reg(8'h2A, 10, "R7");
    expect_reg(8'h2B, 5, "R5");
    expect_reg(8'h2C, 2, "R6");
    expect_reg(8'h2D, 5, "R6");
    expect_reg(8'h2E, 0, "R6");
    expect_reg(8'h20, 32'hC010_000F, "R9");

    // R9 clear status, R8 counts hold
    wr(8'h20, 32'h4000_0000);
    expect_reg(8'h20, 0, "R9");
    #1 chk({31'd0, irq}, 0, "R9", "irq after clear");
    expect_reg(8'h2B, 5, "R8");

    // R3 restart clears, R4 request vs grant, R8 free run then stop
    wr(8'h20, 32'h8000_0001);
    expect_reg(8'h29, 0, "R3");
    expect_reg(8'h2D, 0, "R3");
    for (int i = 0; i < 6; i++) cycle(0, 8'h29, 0, 1, (i % 2) == 0, 5'd3, 0);
    expect_reg(8'h29, 6, "R4");
    expect_reg(8'h2A, 3, "R4");
    expect_reg(8'h2B, 3, "R5");
    wr(8'h20, 32'h0000_0001);
    for (int i = 0; i < 4; i++) cycle(0, 8'h2B, 0, 1, 1, 5'd3, 0);
    expect_reg(8'h2B, 3, "R8");

    // R10 saturation, R11 write priority
    wr(8'h20, 32'h8000_0001);
    wr(8'h2B, 32'hFFFF_FFFE);
    for (int i = 0; i < 4; i++) cycle(0, 8'h2B, 0, 1, 1, 5'd3, 0);
    expect_reg(8'h2B, 32'hFFFF_FFFF, "R10");
    cycle(1, 8'h2B, 32'd7, 1, 1, 5'd3, 0);
    expect_reg(8'h2B, 7, "R11");
    cycle(0, 8'h2B, 0, 1, 0, 5'd3, 0);
    expect_reg(8'h2B, 7, "R4");

    // R12 control write at the expiry cycle
    wr(8'h2F, 32'd3);
    wr(8'h20, 32'h8010_0001);
    cycle(0, 8'h20, 0, 0, 0, 0, 0);
    cycle(0, 8'h20, 0, 0, 0, 0, 0);
    wr(8'h20, 32'h0010_0000);
    expect_reg(8'h20, 32'h0010_0000, "R12");

    // R2 map edges
    wr(8'h30, 32'hFFFF_FFFF);
    expect_reg(8'h30, 0, "R2");
    expect_reg(8'h1F, 0, "R2");
    wr(8'h26, 32'hABCD_1234);
    expect_reg(8'h26, 32'h0000_1234, "R2");

    // randomised traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit [7:0] a = 8'($urandom_range(8'h1E, 8'h31));
      bit [4:0] p = ($urandom_range(0, 3) == 0) ? 5'd23 : 5'($urandom_range(0, 7));
      bit [31:0] d;
      if (r < 4) begin
        d = $urandom;
        d[31] = ($urandom_range(0, 9) < 7);
        cycle(1, 8'h20, d, $urandom_range(0, 1), $urandom_range(0, 1), p, 4'($urandom));
      end else if (r < 6) begin
        wr(8'h2F, $urandom_range(0, 30));
      end else if (r < 10) begin
        wr(8'($urandom_range(8'h21, 8'h28)), $urandom);
      end else if (r < 11) begin
        cycle(1, 8'($urandom_range(8'h29, 8'h2E)), 32'hFFFF_FFFF - $urandom_range(0, 3),
              1, 1, p, 4'($urandom));
      end else begin
        cycle(0, a, 0, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, p, 4'($urandom));
      end
    end
    cycle(0, 8'h20, 0, 0, 0, 0, 0);
    summary();
  end
endmodule